// File: doc/BRIEF.md
# Transaction-Layer Header Rule Checker

This block looks at one PCI Express request or completion header per cycle and reports, a cycle later, every header rule that the packet breaks. The header arrives as parallel doublewords (the first three are enough for all rules checked here) together with a valid strobe. The block decodes the format and type fields and classifies the packet as a memory, IO, configuration, message or completion packet. It then applies that kind's limits on length, traffic class, attributes and byte enables. For any packet that carries data, it also checks the payload length against a programmable maximum payload size.

Each rule owns one bit of the error vector, so a header that breaks several rules raises several bits together. The block is meant to sit on a receive or transmit header path and feed a malformed-packet handler. Payload, end-to-end CRC, flow control and completion matching are handled elsewhere.

Top module: `tlp_hdr_checker`

## Requirements
- R1: `chk_vld_o` is high in the cycle after each cycle with `hdr_vld_i` high and low otherwise; `err_o` is all zero whenever `chk_vld_o` is low, and both are zero after reset.
- R2: Header doubleword 0 holds format in bits 30:29 (bit 30 = data present, bit 29 = 4 DW header), type in 28:24, traffic class in 22:20, relaxed ordering in bit 13, no snoop in bit 12, and length in 9:0.
- R2 (continued): Recognised kinds are memory (type 0 with any format; type 1 with no data), IO (type 2), configuration (types 4 and 5) and completion (types 10 and 11), all with a 3 DW format. Messages are types 16 to 21 with a 4 DW format; type bits 2:0 are the routing sub-field, and routing values 6 and 7 are not recognised.
- R2 (continued): Any other combination sets `err_o[0]` and clears `err_o[6:2]`.
- R3: A non-zero traffic class sets `err_o[1]` for every header, recognised or not.
- R4: An IO, configuration or message header with relaxed ordering or no snoop set raises `err_o[2]`.
- R5: `err_o[3]` is set when an IO or configuration header has a length field other than 1, or when a message with data has a length field other than 1.
- R6: For memory, IO and configuration headers, doubleword 1 carries the last-DW byte enable in bits 7:4 and the first-DW byte enable in bits 3:0. With a DW count of 1, the first enable must be non-zero and the last must be zero. With a larger count, both must be non-zero. Otherwise `err_o[4]` is set. A length field of 0 counts as 1024 DW. Completions and messages never raise this bit.
- R7: For a recognised header with data, `err_o[5]` is set when 4 times the DW count exceeds 128 shifted left by `max_pld_i` bytes.
- R8: A memory header with a 4 DW format whose doubleword 2 (upper address) is zero raises `err_o[6]`.
- R9: All broken rules of one header are reported in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_vld_i | input | 1 | Header doublewords are valid this cycle |
| hdr_dw0_i | input | 32 | Header doubleword 0 (format, type, class, attributes, length) |
| hdr_dw1_i | input | 32 | Header doubleword 1 (byte enables in the low byte) |
| hdr_dw2_i | input | 32 | Header doubleword 2 (upper address for 4 DW memory headers) |
| max_pld_i | input | 3 | Maximum payload size setting |
| chk_vld_o | output | 1 | Result of the header seen in the previous cycle is valid |
| err_o | output | 7 | One bit per broken rule, ordered as in R2 to R8 |

## Verification
The assertions assume that the header and payload-size inputs are known (not X) in every cycle with the valid strobe high. They also assume that the payload-size setting does not change between that cycle and the next edge. The stimulus drives all inputs on the falling edge and keeps them constant across the rising edge. It also drives defined values on idle cycles, so this holds throughout. Directed headers, and random ones with extra weight on the recognised type codes and on small lengths, reach every rule with both legal and illegal values.

// File: rtl/tlp_hdr_checker.sv
module tlp_hdr_checker #(
  parameter int DW_W  = 32,
  parameter int LEN_W = 10,
  parameter int MPS_W = 3,
  parameter int ERR_N = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hdr_vld_i,
  input  logic [DW_W-1:0]  hdr_dw0_i,
  input  logic [DW_W-1:0]  hdr_dw1_i,
  input  logic [DW_W-1:0]  hdr_dw2_i,
  input  logic [MPS_W-1:0] max_pld_i,
  output logic             chk_vld_o,
  output logic [ERR_N-1:0] err_o
);
  localparam int CNT_W = LEN_W + 1;
  localparam int LIM_W = 6 + (1 << MPS_W);

  localparam int E_KIND = 0;
  localparam int E_TC   = 1;
  localparam int E_ATTR = 2;
  localparam int E_LEN  = 3;
  localparam int E_BE   = 4;
  localparam int E_PLD  = 5;
  localparam int E_A64  = 6;

  logic [1:0]       fmt;
  logic [4:0]       typ;
  logic [2:0]       tc;
  logic [1:0]       attr;
  logic [LEN_W-1:0] len;
  logic [3:0]       be_first, be_last;

  assign fmt      = hdr_dw0_i[30:29];
  assign typ      = hdr_dw0_i[28:24];
  assign tc       = hdr_dw0_i[22:20];
  assign attr     = hdr_dw0_i[13:12];
  assign len      = hdr_dw0_i[LEN_W-1:0];
  assign be_first = hdr_dw1_i[3:0];
  assign be_last  = hdr_dw1_i[7:4];

  logic unused_bits;
  assign unused_bits = ^{hdr_dw0_i[DW_W-1], hdr_dw0_i[23], hdr_dw0_i[19:14],
                         hdr_dw0_i[11:LEN_W], hdr_dw1_i[DW_W-1:8]};

  logic is_mem, is_io, is_cfg, is_msg, is_cpl, known;
  assign is_mem = (typ == 5'd0) || (typ == 5'd1 && !fmt[1]);
  assign is_io  = (typ == 5'd2) && !fmt[0];
  assign is_cfg = (typ[4:1] == 4'b0010) && !fmt[0];
  assign is_msg = (typ[4:3] == 2'b10) && (typ[2:1] != 2'b11) && fmt[0];
  assign is_cpl = (typ[4:1] == 4'b0101) && !fmt[0];
  assign known  = is_mem | is_io | is_cfg | is_msg | is_cpl;

  logic [CNT_W-1:0] dw_cnt;
  logic [LIM_W-1:0] pld_lim;
  logic             be_bad, pld_bad;

  assign dw_cnt  = (len == '0) ? CNT_W'(1) << LEN_W : {1'b0, len};
  assign be_bad  = (dw_cnt == CNT_W'(1)) ? (be_first == 4'd0 || be_last != 4'd0)
                                         : (be_first == 4'd0 || be_last == 4'd0);
  assign pld_lim = LIM_W'(32) << max_pld_i;
  assign pld_bad = fmt[1] && (LIM_W'(dw_cnt) > pld_lim);

  logic [ERR_N-1:0] err_d;
  always_comb begin
    err_d         = '0;
    err_d[E_KIND] = !known;
    err_d[E_TC]   = (tc != 3'd0);
    err_d[E_ATTR] = (is_io | is_cfg | is_msg) && (attr != 2'b00);
    err_d[E_LEN]  = ((is_io | is_cfg) && len != LEN_W'(1)) ||
                    (is_msg && fmt[1] && len != LEN_W'(1));
    err_d[E_BE]   = (is_mem | is_io | is_cfg) && be_bad;
    err_d[E_PLD]  = known && pld_bad;
    err_d[E_A64]  = is_mem && fmt[0] && (hdr_dw2_i == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_vld_o <= 1'b0;
      err_o     <= '0;
    end else begin
      chk_vld_o <= hdr_vld_i;
      err_o     <= hdr_vld_i ? err_d : '0;
    end
  end
endmodule

// File: rtl/tlp_hdr_checker_sva.sv
module tlp_hdr_checker_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        hdr_vld_i,
  input logic [31:0] hdr_dw0_i,
  input logic [31:0] hdr_dw2_i,
  input logic [2:0]  max_pld_i,
  input logic        chk_vld_o,
  input logic [6:0]  err_o
);
  assert_pulse_follows_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_vld_i |=> chk_vld_o);
  assert_quiet_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_vld_i |=> (!chk_vld_o && err_o == 7'd0));
  assert_unknown_masks_kind_rules_R2: assert property (@(posedge clk) disable iff (!rst_n)
    err_o[0] |-> (err_o[6:2] == 5'd0));
  assert_class_flagged_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_vld_i && hdr_dw0_i[22:20] != 3'd0) |=> err_o[1]);
  assert_long_write_flagged_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_vld_i && hdr_dw0_i[30:24] == 7'b1000000 && hdr_dw0_i[9:0] == 10'd0
     && max_pld_i < 3'd5) |=> err_o[5]);
  assert_upper_zero_flagged_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_vld_i && hdr_dw0_i[30:24] == 7'b0100000 && hdr_dw2_i == 32'd0) |=> err_o[6]);
endmodule

bind tlp_hdr_checker tlp_hdr_checker_sva u_sva (
  .clk(clk), .rst_n(rst_n), .hdr_vld_i(hdr_vld_i), .hdr_dw0_i(hdr_dw0_i),
  .hdr_dw2_i(hdr_dw2_i), .max_pld_i(max_pld_i), .chk_vld_o(chk_vld_o), .err_o(err_o)
);

// File: tb/tb_tlp_hdr_checker.sv
module tb_tlp_hdr_checker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hdr_vld_i = 1'b0;
  logic [31:0] hdr_dw0_i = '0, hdr_dw1_i = '0, hdr_dw2_i = '0;
  logic [2:0]  max_pld_i = '0;
  logic        chk_vld_o;
  logic [6:0]  err_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tlp_hdr_checker dut (.*);

  function automatic logic [6:0] ref_err(input logic [31:0] a, input logic [31:0] b,
                                         input logic [31:0] c, input int mps);
    int f, t, ln, n, fb, lb;
    bit mem, io, cfg, msg, cpl, ok;
    logic [6:0] e = '0;
    f = int'(a[30:29]); t = int'(a[28:24]); ln = int'(a[9:0]);
    fb = int'(b[3:0]); lb = int'(b[7:4]);
    mem = (t == 0) || (t == 1 && f < 2);
    io  = (t == 2) && (f == 0 || f == 2);
    cfg = (t == 4 || t == 5) && (f == 0 || f == 2);
    msg = (t >= 16 && t <= 21) && (f == 1 || f == 3);
    cpl = (t == 10 || t == 11) && (f == 0 || f == 2);
    ok = mem || io || cfg || msg || cpl;
    if (!ok) e[0] = 1'b1;
    if (a[22:20] != 0) e[1] = 1'b1;
    if (ok) begin
      n = (ln == 0) ? 1024 : ln;
      if ((io || cfg || msg) && a[13:12] != 0) e[2] = 1'b1;
      if ((io || cfg) && ln != 1) e[3] = 1'b1;
      if (msg && f >= 2 && ln != 1) e[3] = 1'b1;
      if (mem || io || cfg) begin
        if (n == 1) e[4] = (fb == 0 || lb != 0);
        else        e[4] = (fb == 0 || lb == 0);
      end
      if (f >= 2 && n * 4 > (128 << mps)) e[5] = 1'b1;
      if (mem && (f == 1 || f == 3) && c == 0) e[6] = 1'b1;
    end
    return e;
  endfunction

  function automatic string tag_of(input int bitpos);
    case (bitpos)
      0: return "R2"; 1: return "R3"; 2: return "R4"; 3: return "R5";
      4: return "R6"; 5: return "R7"; default: return "R8";
    endcase
  endfunction

  // Reference model compared on every clock
  always @(posedge clk) begin
    logic       exp_v;
    logic [6:0] exp_e;
    exp_v = rst_n && hdr_vld_i;
    exp_e = exp_v ? ref_err(hdr_dw0_i, hdr_dw1_i, hdr_dw2_i, int'(max_pld_i)) : 7'd0;
    #1;
    if (!done) begin
      checks++;
      if (chk_vld_o !== exp_v) begin
        errors++;
        $display("FAIL R1 chk_vld_o actual %b expected %b", chk_vld_o, exp_v);
      end
      for (int i = 0; i < 7; i++)
        if (err_o[i] !== exp_e[i]) begin
          errors++;
          $display("FAIL %s err_o[%0d] actual %b expected %b (hdr %h)",
                   tag_of(i), i, err_o[i], exp_e[i], $past(hdr_dw0_i));
        end
    end
  end

  function automatic logic [31:0] mk0(int f, int t, int tc, int at, int ln);
    return {1'b0, 2'(f), 5'(t), 1'b0, 3'(tc), 6'd0, 2'(at), 2'b00, 10'(ln)};
  endfunction

  task automatic send(input logic [31:0] a, input logic [31:0] b,
                      input logic [31:0] c, input int mps);
    @(negedge clk);
    hdr_vld_i = 1'b1; hdr_dw0_i = a; hdr_dw1_i = b; hdr_dw2_i = c; max_pld_i = 3'(mps);
  endtask

  task automatic idle();
    @(negedge clk);
    hdr_vld_i = 1'b0;
  endtask

  task automatic expect_now(input logic [6:0] want, input string tag);
    checks++;
    if (err_o !== want || chk_vld_o !== 1'b1) begin
      errors++;
      $display("FAIL %s err_o actual %b expected %b", tag, err_o, want);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (chk_vld_o !== 1'b0 || err_o !== 7'd0) begin
      errors++;
      $display("FAIL R1 reset state actual %b/%b expected 0/0", chk_vld_o, err_o);
    end
    rst_n = 1'b1;
    // R6 one-DW read legal, then last enable set, then two-DW with first zero
    send(mk0(0, 0, 0, 0, 1), 32'h0F, 0, 0);
    send(mk0(0, 0, 0, 0, 1), 32'h3F, 0, 0);
    send(mk0(0, 0, 0, 0, 2), 32'hF0, 0, 0);
    // R7 1024-DW write with limits 5 and 0; 32 vs 33 DW at limit 0
    send(mk0(2, 0, 0, 0, 0), 32'hFF, 0, 5);
    send(mk0(2, 0, 0, 0, 0), 32'hFF, 0, 0);
    send(mk0(2, 0, 0, 0, 32), 32'hFF, 0, 0);
    send(mk0(2, 0, 0, 0, 33), 32'hFF, 0, 0);
    idle();
    // R5 IO read with length 2; R3 class 1; R4 attribute on configuration write
    send(mk0(0, 2, 0, 0, 2), 32'h0F, 0, 0);
    send(mk0(0, 2, 1, 0, 1), 32'h0F, 0, 0);
    send(mk0(2, 4, 0, 2, 1), 32'h0F, 0, 0);
    // R5 message with data length 2; R4 message attribute; R2 routing 6
    send(mk0(3, 20, 0, 0, 2), 0, 0, 0);
    send(mk0(1, 16, 0, 1, 0), 0, 0, 0);
    send(mk0(1, 22, 0, 0, 0), 32'h12, 0, 0);
    // R2 IO with 4 DW format; R8 64-bit read with zero upper word, then non-zero
    send(mk0(1, 2, 0, 0, 1), 32'h0F, 0, 0);
    send(mk0(1, 0, 0, 0, 1), 32'h0F, 0, 0);
    send(mk0(1, 0, 0, 0, 1), 32'h0F, 32'h1, 0);
    // R6 completion with odd enables is not flagged
    send(mk0(2, 10, 0, 0, 3), 32'h5A, 0, 0);
    // R9 several rules broken by one IO write: class, attr, length, enables
    send(mk0(2, 2, 3, 3, 4), 32'h00, 0, 0);
    @(negedge clk);
    expect_now(7'b0011110, "R9");
    hdr_vld_i = 1'b0;
    // R2 unknown kind with class set still reports class only in addition
    send(mk0(2, 1, 2, 3, 5), 0, 0, 0);
    idle();
    for (int k = 0; k < 600; k++) begin
      int tsel, f, t;
      tsel = int'($urandom_range(0, 11));
      case (tsel)
        0, 1: t = 0; 2: t = 1; 3: t = 2; 4: t = 4; 5: t = 5;
        6: t = 10; 7: t = 11; 8, 9: t = 16 + int'($urandom_range(0, 7));
        default: t = int'($urandom_range(0, 31));
      endcase
      f = int'($urandom_range(0, 3));
      if ($urandom_range(0, 4) == 0) idle();
      send(mk0(f, t, ($urandom_range(0, 5) == 0) ? int'($urandom_range(1, 7)) : 0,
               ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, 3)) : 0,
               ($urandom_range(0, 1) == 0) ? int'($urandom_range(0, 3))
                                           : int'($urandom_range(0, 1023))),
           $urandom(), ($urandom_range(0, 2) == 0) ? 32'd0 : $urandom(),
           int'($urandom_range(0, 7)));
    end
    idle();
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    done = 1;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule